// File: doc/BRIEF.md
# Multichannel SAR ADC Serial Controller

This block is the host-side controller for an eight-input, 12-bit successive-approximation converter that has a four-wire serial port. It turns a 4-bit input select, a bipolar request and a sleep request into a 6-bit setup word. It raises the conversion-start line and holds it for a programmable number of system cycles while the converter works. It then runs a serial frame. In that frame the setup word for the next conversion goes out on the data-out line while the 12 bits of the conversion just finished come back on the data-in line.

The returned sample is widened to a 13-bit two's-complement value. A sample taken in unipolar coding gets a zero in front. A sample taken in bipolar coding gets its sign bit copied in front. The coding used is the one that was sent with the conversion that produced the sample, so it comes from the frame before. A one-cycle strobe marks each new sample. While the enable input is low, the output register holds its value.

The serial clock comes from the system clock divided by 2·`SCLK_DIV`. The default gives 25 MHz from 100 MHz, which is below the converter's 40 MHz limit. The default conversion wait of 160 cycles is 1.6 µs.

Top module: `adc_serial_ctrl`

## Requirements
- R1: The setup word is 6 bits and goes out MSB first as {S/D, O/S, S1, S0, UNI, SLP}. For selects 0..7 (single-ended input n against the common pin), S/D=1, O/S=sel[0], S1=sel[2] and S0=sel[1]. Select 1 therefore gives 1100 in the upper four bits, and select 2 gives 1001.
- R2: For selects 8..15 (differential pairs), S/D=0 and O/S, S1, S0 come from the same select bits as in R1. Select 8 gives 0000, select 9 gives 0100 and select 14 gives 0011.
- R3: UNI is the inverse of the `bipolar` input, and SLP equals `sleep_sel`.
- R4: `adc_convst` rises one cycle after a frame ends. It stays high for exactly `CONV_WAIT` system cycles and then drops as the frame begins. It is never high while `adc_sclk` is high.
- R5: Each frame has exactly 12 serial clock pulses, each high for `SCLK_DIV` system cycles. `adc_mosi` changes only when `adc_sclk` falls, and the first bit is on the line before the first rising edge.
- R6: `adc_miso` is sampled on each rising serial clock edge, MSB first, and the 12 samples form the returned word.
- R7: The output loads at the 12th falling serial clock edge. The value is {0, word} if the conversion's setup word had UNI=1, and {word[11], word} if it had UNI=0. Before any setup word has been sent, unipolar coding is assumed.
- R8: `result_valid` is high for exactly one cycle per loaded sample. `result` does not change in any other cycle.
- R9: If `enable` is low at the end of a frame, `result` keeps its previous value and no strobe is produced.
- R10: The select, bipolar and sleep inputs are captured once, at the start of each frame. Changes during a frame do not alter the word being sent or the coding used for the next sample.
- R11: While `rst` is high, `result`, `result_valid`, `adc_convst`, `adc_sclk` and `adc_mosi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | When low, the output register is frozen |
| chan_sel | input | 4 | Input select: 0..7 single-ended, 8..15 differential |
| bipolar | input | 1 | Requests two's-complement coding for the next conversion |
| sleep_sel | input | 1 | Requests sleep instead of nap after the next conversion |
| adc_convst | output | 1 | Conversion start, high during the conversion wait |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_mosi | output | 1 | Setup word to the converter |
| adc_miso | input | 1 | Conversion result from the converter |
| result | output | 13 | Extended sample, two's complement |
| result_valid | output | 1 | One-cycle strobe for a new sample |

## Verification
The assertions check these properties on every cycle:
- the start line is low whenever the serial clock is high;
- the data-out line is steady while the serial clock is high;
- the bit counter never passes 12;
- the strobe is a single cycle, and the output does not move without it;
- the top output bit is set only when bit 11 is also set.

The bench's scenarios show the rest:
- the bit order and the select encodings, using a converter model that captures the serial stream;
- the one-frame delay of the coding in force;
- the output freeze while enable is low;
- the effect of changing inputs in the middle of a frame;
- the length of the start pulse and the number of serial pulses, which the bench counts in system cycles.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

  localparam int CFG_W   = 6;
  localparam int SEL_W   = 4;
  localparam int UNI_POS = 1;

  typedef enum logic [1:0] {
    SEQ_GAP   = 2'd0,
    SEQ_CONV  = 2'd1,
    SEQ_FRAME = 2'd2
  } seq_state_e;

  // Setup word, MSB sent first: {single/diff, odd/sign, s1, s0, uni, slp}
  function automatic logic [CFG_W-1:0] build_cfg(input logic [SEL_W-1:0] sel,
                                                 input logic bip,
                                                 input logic slp);
    return {~sel[3], sel[0], sel[2], sel[1], ~bip, slp};
  endfunction

endpackage

// File: rtl/adcs_sequencer.sv
module adcs_sequencer #(
  parameter int CONV_WAIT = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_done,
  output logic convst,
  output logic in_frame,
  output logic frame_start
);
  import adcs_pkg::*;

  localparam int WAIT_W = (CONV_WAIT > 1) ? $clog2(CONV_WAIT) : 1;

  seq_state_e        state;
  logic [WAIT_W-1:0] wcnt;

  assign frame_start = (state == SEQ_CONV) && (wcnt == WAIT_W'(CONV_WAIT - 1));
  assign in_frame    = (state == SEQ_FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_GAP;
      wcnt   <= '0;
      convst <= 1'b0;
    end else begin
      unique case (state)
        SEQ_GAP: begin
          state  <= SEQ_CONV;
          convst <= 1'b1;
          wcnt   <= '0;
        end
        SEQ_CONV: begin
          if (frame_start) begin
            state  <= SEQ_FRAME;
            convst <= 1'b0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        SEQ_FRAME: begin
          if (frame_done) state <= SEQ_GAP;
        end
        default: state <= SEQ_GAP;
      endcase
    end
  end

  // R4: a frame may only begin while the start line is still high
  a_r4_wait_ends_with_convst_high: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> convst);

endmodule

// File: rtl/adcs_sclk_gen.sv
module adcs_sclk_gen #(
  parameter int SCLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick      = run && (cnt == CW'(SCLK_DIV - 1));
  assign rise_tick = tick && !sclk;
  assign fall_tick = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: the serial clock is only ever high inside a frame
  a_r5_sclk_only_in_frame: assert property (@(posedge clk) disable iff (rst)
    sclk |-> run);

endmodule

// File: rtl/adcs_shift_engine.sv
module adcs_shift_engine #(
  parameter int RES_W = 12,
  parameter int CFG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             miso,
  output logic             mosi,
  output logic [RES_W-1:0] rx_word,
  output logic             frame_done,
  output logic             frame_uni
);
  import adcs_pkg::UNI_POS;

  localparam int BW = $clog2(RES_W + 1);

  logic [CFG_W-1:0] tx;
  logic [BW-1:0]    bit_cnt;

  assign frame_done = fall_tick && (bit_cnt == BW'(RES_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx        <= '0;
      mosi      <= 1'b0;
      rx_word   <= '0;
      bit_cnt   <= '0;
      frame_uni <= 1'b1;
    end else if (load) begin
      tx        <= cfg_in;
      mosi      <= cfg_in[CFG_W-1];
      bit_cnt   <= '0;
      frame_uni <= cfg_in[UNI_POS];
    end else begin
      if (rise_tick) rx_word <= {rx_word[RES_W-2:0], miso};
      if (fall_tick) begin
        tx      <= {tx[CFG_W-2:0], 1'b0};
        mosi    <= tx[CFG_W-2];
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R5: never more serial bits than the result width
  a_r5_bit_count_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BW'(RES_W));

endmodule

// File: rtl/adcs_result_stage.sv
module adcs_result_stage #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             frame_done,
  input  logic             frame_uni,
  input  logic [RES_W-1:0] rx_word,
  output logic [RES_W:0]   result,
  output logic             result_valid
);
  // coding that applied to the conversion whose bits arrive in this frame
  logic uni_in_force;

  always_ff @(posedge clk) begin
    if (rst) begin
      uni_in_force <= 1'b1;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (frame_done) begin
        uni_in_force <= frame_uni;
        if (enable) begin
          result       <= uni_in_force ? {1'b0, rx_word} : {rx_word[RES_W-1], rx_word};
          result_valid <= 1'b1;
        end
      end
    end
  end

  a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));

  // R7: the extension bit is set only when it copies a set sign bit
  a_r7_extension_consistent: assert property (@(posedge clk) disable iff (rst)
    result[RES_W] |-> result[RES_W-1]);

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
  parameter int SCLK_DIV  = 2,
  parameter int CONV_WAIT = 160,
  parameter int RES_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [3:0]       chan_sel,
  input  logic             bipolar,
  input  logic             sleep_sel,
  output logic             adc_convst,
  output logic             adc_sclk,
  output logic             adc_mosi,
  input  logic             adc_miso,
  output logic [RES_W:0]   result,
  output logic             result_valid
);
  import adcs_pkg::*;

  logic             in_frame, frame_start, frame_done;
  logic             rise_tick, fall_tick, frame_uni;
  logic [RES_W-1:0] rx_word;
  logic [CFG_W-1:0] cfg_now;

  assign cfg_now = build_cfg(chan_sel, bipolar, sleep_sel);

  adcs_sequencer #(.CONV_WAIT(CONV_WAIT)) u_seq (
    .clk(clk), .rst(rst), .frame_done(frame_done),
    .convst(adc_convst), .in_frame(in_frame), .frame_start(frame_start)
  );

  adcs_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_sclk (
    .clk(clk), .rst(rst), .run(in_frame),
    .sclk(adc_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  adcs_shift_engine #(.RES_W(RES_W), .CFG_W(CFG_W)) u_shift (
    .clk(clk), .rst(rst), .load(frame_start), .cfg_in(cfg_now),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .miso(adc_miso),
    .mosi(adc_mosi), .rx_word(rx_word), .frame_done(frame_done),
    .frame_uni(frame_uni)
  );

  adcs_result_stage #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .enable(enable), .frame_done(frame_done),
    .frame_uni(frame_uni), .rx_word(rx_word),
    .result(result), .result_valid(result_valid)
  );

  a_r4_convst_low_while_sclk_high: assert property (@(posedge clk) disable iff (rst)
    adc_sclk |-> !adc_convst);

  a_r5_mosi_steady_while_high: assert property (@(posedge clk) disable iff (rst)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_mosi));

endmodule

// File: tb/tb_adc_serial_ctrl.sv
`timescale 1ns/1ps
module tb_adc_serial_ctrl;
  localparam int DIV  = 2;
  localparam int WAIT = 160;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic [3:0]  chan_sel = '0;
  logic        bipolar = 1'b0;
  logic        sleep_sel = 1'b0;
  logic        adc_convst, adc_sclk, adc_mosi, adc_miso;
  logic [12:0] result;
  logic        result_valid;

  always #5 clk = ~clk;

  adc_serial_ctrl #(.SCLK_DIV(DIV), .CONV_WAIT(WAIT), .RES_W(12)) dut (
    .clk(clk), .rst(rst), .enable(enable), .chan_sel(chan_sel),
    .bipolar(bipolar), .sleep_sel(sleep_sel), .adc_convst(adc_convst),
    .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(adc_miso),
    .result(result), .result_valid(result_valid)
  );

  // converter model: word loaded at start rise, shifted out on falls, setup captured on rises
  logic [11:0] next_word = '0;
  logic [11:0] m_shift = '0;
  logic [5:0]  cap = '0;
  int          ncap = 0;
  logic        m_cs_q = 1'b0, m_sclk_q = 1'b0;

  assign adc_miso = m_shift[11];

  always @(posedge clk) begin
    m_cs_q   <= adc_convst;
    m_sclk_q <= adc_sclk;
    if (adc_convst && !m_cs_q) begin
      m_shift <= next_word;
      cap     <= '0;
      ncap    <= 0;
    end else begin
      if (!adc_sclk && m_sclk_q) m_shift <= {m_shift[10:0], 1'b0};
      if (adc_sclk && !m_sclk_q && ncap < 6) begin
        cap  <= {cap[4:0], adc_mosi};
        ncap <= ncap + 1;
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [11:0] pend_word;
  logic [3:0]  pend_sel;
  logic        pend_bip, pend_slp, pend_en;
  logic        exp_uni = 1'b1;
  logic [12:0] last_result = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] widen(input logic [11:0] w, input logic uni);
    return uni ? {1'b0, w} : {w[11], w};
  endfunction

  task automatic stage(input logic [11:0] w, input logic [3:0] sel,
                       input logic bip, input logic slp, input logic en);
    next_word = w; chan_sel = sel; bipolar = bip; sleep_sel = slp; enable = en;
    pend_word = w; pend_sel = sel; pend_bip = bip; pend_slp = slp; pend_en = en;
  endtask

  task automatic finish_frame(input string cfg_req, input string res_req, input bit garble);
    int falls = 0, rises = 0, cs_hi = 0, hi = 0, vhi = 0;
    logic prev = adc_sclk;
    logic [5:0]  exp_cfg;
    logic [12:0] exp_res;
    while (falls < 12) begin
      @(negedge clk);
      if (adc_convst) cs_hi++;
      if (adc_sclk) hi++;
      if (result_valid) vhi++;
      if (adc_sclk && !prev) begin
        rises++;
        if (garble && rises == 1) begin
          chan_sel = ~pend_sel; bipolar = ~pend_bip; sleep_sel = ~pend_slp;
        end
      end
      if (!adc_sclk && prev) falls++;
      prev = adc_sclk;
    end
    exp_cfg = {~pend_sel[3], pend_sel[0], pend_sel[2], pend_sel[1], ~pend_bip, pend_slp};
    exp_res = pend_en ? widen(pend_word, exp_uni) : last_result;
    check(cs_hi == WAIT, "R4", "start pulse cycles", cs_hi, WAIT);
    check(hi == 12 * DIV, "R5", "sclk high cycles", hi, 12 * DIV);
    check(cap == exp_cfg, cfg_req, "setup word", cap, exp_cfg);
    check(result == exp_res, res_req, "result", result, exp_res);
    check(vhi == (pend_en ? 1 : 0), "R8", "strobe cycles", vhi, pend_en ? 1 : 0);
    exp_uni     = ~pend_bip;
    last_result = exp_res;
  endtask

  task automatic t_reset;
    stage(12'hFFF, 4'd0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check(result == 0, "R11", "result", result, 0);
    check(result_valid == 0, "R11", "valid", result_valid, 0);
    check(adc_convst == 0, "R11", "convst", adc_convst, 0);
    check(adc_sclk == 0, "R11", "sclk", adc_sclk, 0);
    check(adc_mosi == 0, "R11", "mosi", adc_mosi, 0);
    rst = 1'b0;
  endtask

  task automatic t_single_ended;
    finish_frame("R1", "R7", 0);               // first sample, unipolar assumed
    stage(12'h123, 4'd1, 1'b0, 1'b0, 1'b1);
    finish_frame("R1", "R6", 0);
    stage(12'hABC, 4'd2, 1'b0, 1'b0, 1'b1);
    finish_frame("R1", "R6", 0);
    stage(12'h7FF, 4'd7, 1'b0, 1'b0, 1'b1);
    finish_frame("R1", "R7", 0);
  endtask

  task automatic t_differential;
    stage(12'h800, 4'd8, 1'b1, 1'b0, 1'b1);
    finish_frame("R2", "R7", 0);               // coding still unipolar from previous word
    stage(12'h800, 4'd9, 1'b1, 1'b0, 1'b1);
    finish_frame("R2", "R7", 0);               // now -2048
    stage(12'hFFF, 4'd14, 1'b1, 1'b0, 1'b1);
    finish_frame("R2", "R7", 0);
    stage(12'h7FF, 4'd15, 1'b0, 1'b0, 1'b1);
    finish_frame("R2", "R7", 0);
  endtask

  task automatic t_sleep;
    stage(12'h001, 4'd3, 1'b0, 1'b1, 1'b1);
    finish_frame("R3", "R6", 0);
    stage(12'hF0F, 4'd11, 1'b1, 1'b0, 1'b1);
    finish_frame("R3", "R7", 0);
  endtask

  task automatic t_enable_freeze;
    stage(12'h555, 4'd5, 1'b0, 1'b0, 1'b0);
    finish_frame("R1", "R9", 0);
    stage(12'h0AA, 4'd4, 1'b0, 1'b0, 1'b1);
    finish_frame("R1", "R9", 0);
  endtask

  task automatic t_midframe;
    stage(12'h3C3, 4'd6, 1'b1, 1'b0, 1'b1);
    finish_frame("R10", "R7", 1);
    stage(12'hFFF, 4'd0, 1'b0, 1'b0, 1'b1);
    finish_frame("R1", "R10", 0);              // coding follows captured bipolar request
  endtask

  initial begin
    t_reset();
    t_single_ended();
    t_differential();
    t_sleep();
    t_enable_freeze();
    t_midframe();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule